// File: doc/BRIEF.md
# Two-Plane Bad-Block Pairing Mapper

This block sits in front of a flash array made of two planes that can work in parallel. Each plane has its own scattered bad blocks. The block keeps a separate bad-block record for each plane. From those records it builds logical units, each of which holds one good block from each plane. The two blocks in a unit can sit at different indices in their planes. Because of this, a bad block in one plane never takes the good block at the same index in the other plane out of use.

Pairs are formed by walking both planes in ascending block order. The k-th good block of plane 0 is paired with the k-th good block of plane 1. The number of logical units is the smaller of the two good-block totals.

A caller asks for a logical unit and a page. One cycle later the block returns both physical block indices together with the page offset, which is shared by both planes, for a concurrent two-plane operation. Both planes use the same page offset, as a joint operation requires.

Marking a block bad at run time updates that plane's record and starts a rebuild of the pair table. The rebuild takes one cycle per block index. A busy flag is high for the whole rebuild, and requests made while it is high are dropped.

Top module: `planePairMapper`

## Requirements
- R1: After reset, `busy` is high for exactly NUM_BLOCKS cycles and `pairValid` and `rangeErr` are low. With no block marked, unit k then maps to block k on both planes.
- R2: Each plane has its own bad-block record. Marking block b bad on one plane (`markPlane` 0 selects plane 0, 1 selects plane 1) leaves block b of the other plane in use.
- R3: Unit k maps to the k-th good block of plane 0 on `plane0Block` and to the k-th good block of plane 1 on `plane1Block`, both counted in ascending index order from zero.
- R4: The unit count equals the smaller of the two planes' good-block counts. An accepted request with `reqUnit` at or above that count gives `rangeErr` high and `pairValid` low for one cycle. `rangeErr` and `pairValid` are never high together.
- R5: When `pairValid` is high, `pageOut` equals the `reqPage` of the request, and this single offset applies to both planes.
- R6: A request accepted in cycle n produces its result (`pairValid` or `rangeErr`) in cycle n+1 only, for one cycle.
- R7: Marking a block raises `busy` in the next cycle and holds it for exactly NUM_BLOCKS cycles. A request made while `busy` is high produces neither `pairValid` nor `rangeErr`.
- R8: When a mark and a request arrive in the same cycle, the mark takes effect and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| markValid | input | 1 | Strobe to mark one block bad |
| markPlane | input | 1 | Plane of the block to mark |
| markBlock | input | BLK_W | Index of the block to mark |
| reqValid | input | 1 | Translation request strobe |
| reqUnit | input | BLK_W | Logical unit requested |
| reqPage | input | PAGE_W | Page offset inside the unit |
| busy | output | 1 | Pair table rebuild in progress |
| pairValid | output | 1 | Address pair valid this cycle |
| rangeErr | output | 1 | Requested unit beyond unit count |
| plane0Block | output | BLK_W | Physical block on plane 0 |
| plane1Block | output | BLK_W | Physical block on plane 1 |
| pageOut | output | PAGE_W | Page offset shared by both planes |

## Verification
Two functions can fall in the same cycle: a run-time mark, which restarts the rebuild, and a translation request. The bench provokes this by driving `markValid` and `reqValid` on the same clock. It then judges that no result appears, that `busy` rises, and that after the rebuild the new mark is reflected in the unit map. A second overlap, a request made during a rebuild, is provoked in the middle of the scan and must produce no output. Between marks, every logical unit is swept and its block pair is compared with the k-th good block that the bench computes from its own copy of both bad-block records.

// File: rtl/planePairPkg.sv
package planePairPkg;
  typedef struct packed {
    logic clrScan;
    logic scanEn;
    logic finish;
    logic accept;
  } ctrlStrobes_t;
endpackage

// File: rtl/planePairCtrl.sv
module planePairCtrl
  import planePairPkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             markValid,
  input  logic             reqValid,
  output logic             busy,
  output logic [BLK_W-1:0] scanIdx,
  output ctrlStrobes_t     strobes
);
  localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b1;
      scanIdx <= '0;
    end else if (markValid) begin
      busy    <= 1'b1;
      scanIdx <= '0;
    end else if (busy) begin
      if (scanIdx == LAST_IDX) busy <= 1'b0;
      else scanIdx <= scanIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.clrScan = markValid;
    strobes.scanEn  = busy && !markValid;
    strobes.finish  = busy && !markValid && (scanIdx == LAST_IDX);
    strobes.accept  = reqValid && !busy && !markValid;
  end
endmodule

// File: rtl/planeScanner.sv
module planeScanner #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             markEn,
  input  logic [BLK_W-1:0] markBlock,
  input  logic             clrScan,
  input  logic             scanEn,
  input  logic [BLK_W-1:0] scanIdx,
  input  logic [BLK_W-1:0] lookIdx,
  output logic [CNT_W-1:0] goodNext,
  output logic [BLK_W-1:0] lookBlock
);
  logic [NUM_BLOCKS-1:0] badMap;
  logic [BLK_W-1:0]      goodTab [NUM_BLOCKS];
  logic [CNT_W-1:0]      goodCnt;
  logic                  hereGood;

  assign hereGood  = scanEn && !badMap[scanIdx];
  assign goodNext  = goodCnt + CNT_W'(hereGood);
  assign lookBlock = goodTab[lookIdx];

  always_ff @(posedge clk) begin
    if (rst) badMap <= '0;
    else if (markEn) badMap[markBlock] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clrScan) goodCnt <= '0;
    else if (scanEn) goodCnt <= goodNext;
  end

  always_ff @(posedge clk) begin
    if (hereGood) goodTab[goodCnt[BLK_W-1:0]] <= scanIdx;
  end
endmodule

// File: rtl/planePairData.sv
module planePairData
  import planePairPkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int PAGES_PER_BLOCK = 8,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK),
  localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [BLK_W-1:0]  scanIdx,
  input  logic              markValid,
  input  logic              markPlane,
  input  logic [BLK_W-1:0]  markBlock,
  input  logic [BLK_W-1:0]  reqUnit,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              pairValid,
  output logic              rangeErr,
  output logic [BLK_W-1:0]  plane0Block,
  output logic [BLK_W-1:0]  plane1Block,
  output logic [PAGE_W-1:0] pageOut
);
  logic [CNT_W-1:0] goodNext [2];
  logic [BLK_W-1:0] lookBlock [2];
  logic [CNT_W-1:0] unitCount;
  logic             inRange;

  for (genvar p = 0; p < 2; p++) begin : g_plane
    planeScanner #(.NUM_BLOCKS(NUM_BLOCKS)) scan_i (
      .clk      (clk),
      .rst      (rst),
      .markEn   (markValid && (markPlane == 1'(p))),
      .markBlock(markBlock),
      .clrScan  (strobes.clrScan),
      .scanEn   (strobes.scanEn),
      .scanIdx  (scanIdx),
      .lookIdx  (reqUnit),
      .goodNext (goodNext[p]),
      .lookBlock(lookBlock[p])
    );
  end

  assign inRange = CNT_W'(reqUnit) < unitCount;

  always_ff @(posedge clk) begin
    if (rst) unitCount <= '0;
    else if (strobes.finish)
      unitCount <= (goodNext[0] < goodNext[1]) ? goodNext[0] : goodNext[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pairValid   <= 1'b0;
      rangeErr    <= 1'b0;
      plane0Block <= '0;
      plane1Block <= '0;
      pageOut     <= '0;
    end else begin
      pairValid <= strobes.accept && inRange;
      rangeErr  <= strobes.accept && !inRange;
      if (strobes.accept && inRange) begin
        plane0Block <= lookBlock[0];
        plane1Block <= lookBlock[1];
        pageOut     <= reqPage;
      end
    end
  end
endmodule

// File: rtl/planePairMapper.sv
module planePairMapper
  import planePairPkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int PAGES_PER_BLOCK = 8,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              markValid,
  input  logic              markPlane,
  input  logic [BLK_W-1:0]  markBlock,
  input  logic              reqValid,
  input  logic [BLK_W-1:0]  reqUnit,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              busy,
  output logic              pairValid,
  output logic              rangeErr,
  output logic [BLK_W-1:0]  plane0Block,
  output logic [BLK_W-1:0]  plane1Block,
  output logic [PAGE_W-1:0] pageOut
);
  ctrlStrobes_t     strobes;
  logic [BLK_W-1:0] scanIdx;

  planePairCtrl #(.NUM_BLOCKS(NUM_BLOCKS)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .markValid(markValid),
    .reqValid (reqValid),
    .busy     (busy),
    .scanIdx  (scanIdx),
    .strobes  (strobes)
  );

  planePairData #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) data_i (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .scanIdx    (scanIdx),
    .markValid  (markValid),
    .markPlane  (markPlane),
    .markBlock  (markBlock),
    .reqUnit    (reqUnit),
    .reqPage    (reqPage),
    .pairValid  (pairValid),
    .rangeErr   (rangeErr),
    .plane0Block(plane0Block),
    .plane1Block(plane1Block),
    .pageOut    (pageOut)
  );
endmodule

// File: rtl/planePairMapperChk.sv
module planePairMapperChk #(
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              markValid,
  input logic              reqValid,
  input logic [PAGE_W-1:0] reqPage,
  input logic              busy,
  input logic              pairValid,
  input logic              rangeErr,
  input logic [PAGE_W-1:0] pageOut
);
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(pairValid && rangeErr));

  p_page_r5: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> (pairValid -> (pageOut == $past(reqPage))));

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!pairValid && !rangeErr));

  p_mark_busy_r7: assert property (@(posedge clk) disable iff (rst)
    markValid |=> busy);

  p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && busy) |=> (!pairValid && !rangeErr));

  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && markValid) |=> (!pairValid && !rangeErr));
endmodule

bind planePairMapper planePairMapperChk #(.PAGE_W(PAGE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .markValid(markValid),
  .reqValid (reqValid),
  .reqPage  (reqPage),
  .busy     (busy),
  .pairValid(pairValid),
  .rangeErr (rangeErr),
  .pageOut  (pageOut)
);

// File: tb/planePairMapper_tb.sv
module planePairMapper_tb_top;
  localparam int NB = 16;
  localparam int NP = 8;
  localparam int BW = $clog2(NB);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic markValid = 1'b0;
  logic markPlane = 1'b0;
  logic [BW-1:0] markBlock = '0;
  logic reqValid = 1'b0;
  logic [BW-1:0] reqUnit = '0;
  logic [PW-1:0] reqPage = '0;
  logic busy, pairValid, rangeErr;
  logic [BW-1:0] plane0Block, plane1Block;
  logic [PW-1:0] pageOut;

  int checks = 0;
  int errors = 0;
  bit bad [2][NB];

  always #2.5 clk = ~clk;

  planePairMapper #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(NP)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int goodCount(input int p);
    int c = 0;
    for (int i = 0; i < NB; i++) if (!bad[p][i]) c++;
    return c;
  endfunction

  function automatic int kthGood(input int p, input int k);
    int c = 0;
    for (int i = 0; i < NB; i++) if (!bad[p][i]) begin
      if (c == k) return i;
      c++;
    end
    return -1;
  endfunction

  task automatic countBusy(input string req);
    int n = 0;
    while (busy && n < 4 * NB) begin
      n++;
      @(negedge clk);
    end
    check(n == NB, req, n, NB);
  endtask

  task automatic markOne(input int p, input int b);
    markValid = 1'b1; markPlane = 1'(p); markBlock = BW'(b);
    bad[p][b] = 1'b1;
    @(negedge clk);
    markValid = 1'b0;
    countBusy("R7 busy length");
  endtask

  task automatic reqOne(input int u, input int pg);
    int units = goodCount(0) < goodCount(1) ? goodCount(0) : goodCount(1);
    reqValid = 1'b1; reqUnit = BW'(u); reqPage = PW'(pg);
    @(negedge clk);
    reqValid = 1'b0;
    if (u < units) begin
      check(pairValid && !rangeErr, "R4 in-range valid", pairValid, 1);
      check(plane0Block == BW'(kthGood(0, u)), "R3 plane0 block", plane0Block, kthGood(0, u));
      check(plane1Block == BW'(kthGood(1, u)), "R3 plane1 block", plane1Block, kthGood(1, u));
      check(pageOut == PW'(pg), "R5 page offset", pageOut, pg);
    end else begin
      check(rangeErr && !pairValid, "R4 out of range", rangeErr, 1);
    end
    @(negedge clk);
    check(!pairValid && !rangeErr, "R6 single-cycle result", pairValid | rangeErr, 0);
  endtask

  task automatic sweep();
    for (int u = 0; u < NB; u++) reqOne(u, (u * 3 + 1) % NP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pairValid && !rangeErr && busy, "R1 reset state", pairValid | rangeErr, 0);
    rst = 1'b0;
    countBusy("R1 reset busy length");
    sweep();                         // R1 identity map

    markOne(0, 0);                   // R2: plane1 block 0 stays in use
    reqOne(0, 5);
    check(plane1Block == 0, "R2 other plane kept", plane1Block, 0);
    sweep();

    markOne(0, 3); markOne(0, 5); markOne(1, 5); markOne(1, 15);
    sweep();                         // R3 unaligned pairs, R4 range

    // R7: request mid-rebuild is dropped
    markValid = 1'b1; markPlane = 1'b1; markBlock = 4'd2; bad[1][2] = 1'b1;
    @(negedge clk);
    markValid = 1'b0;
    repeat (4) @(negedge clk);
    reqValid = 1'b1; reqUnit = '0;
    @(negedge clk);
    reqValid = 1'b0;
    check(!pairValid && !rangeErr, "R7 request during busy", pairValid | rangeErr, 0);
    while (busy) @(negedge clk);
    sweep();

    // R8: mark and request together
    markValid = 1'b1; markPlane = 1'b0; markBlock = 4'd8; bad[0][8] = 1'b1;
    reqValid = 1'b1; reqUnit = 4'd1;
    @(negedge clk);
    markValid = 1'b0; reqValid = 1'b0;
    check(!pairValid && !rangeErr, "R8 collided request dropped", pairValid | rangeErr, 0);
    check(busy, "R8 mark took effect", busy, 1);
    while (busy) @(negedge clk);
    sweep();

    markOne(1, 2);                   // already bad: map unchanged
    sweep();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule